// File: doc/BRIEF.md
# Flash Write Completion Poller

This controller sits on the host side of a parallel NOR flash and waits for an internal program or erase to finish. The command sequence is issued elsewhere. Once the last write strobe of that command has been given, the host pulses `start`. From then on the poller keeps requesting status reads over a simple request/acknowledge read port and examines each returned word until the operation is over. It then raises either `done` or `fail`.

Two detection methods are supported, and `pollMode` selects between them.

- **Data-complement mode** (`pollMode`=0) watches the flag bit. During a program, the flag bit reads as the inverse of the bit being written. During an erase, it reads 0. The true value (or 1 for an erase) appears once the operation has finished.
- **Toggle mode** (`pollMode`=1) watches the toggle bit. That bit flips on every read while the operation runs and freezes when it ends.

The flash finishes at a moment that has no relation to the reads. A single read that looks finished is therefore only trusted after two further reads agree with it. In data-complement mode the poller then waits a settle interval, because the rest of the data bus becomes valid only after a short delay. It then checks the full word.

A status-read budget turns a stuck operation into `fail`.

Top module: `flash_done_poller`

## Requirements
- R1: While reset is asserted and after its release, `busy`, `done`, `fail` and `rdReq` are all low.
- R2: A `start` pulse seen while not busy sets `busy` and `rdReq` in the next cycle. Once `rdReq` is asserted, it stays high until `rdAck`. `rdReq` is never high while `busy` is low.
- R3: In data-complement mode, a status read counts as finished when bit 7 of `rdData` matches a target value. For a program (`isErase`=0) the target is bit 7 of `expData`. For an erase (`isErase`=1) the target is 1.
- R4: In toggle mode, a status read counts as finished when bit 6 of `rdData` equals bit 6 of the previous status read of the same operation. The first status read after `start` never counts as finished.
- R5: An operation is confirmed only by a finished-looking status read followed by two more finished-looking status reads in a row. Any status read that does not look finished restarts this count.
- R6: In data-complement mode, a confirmation is followed by SETTLE_CYC cycles with `busy` high and `rdReq` low. One full-word read follows. If that word equals the expected word (`expData` for a program, all ones for an erase), the result is `done`; otherwise it is `fail`.
- R7: In toggle mode, a confirmation gives `done` right away, with no settle interval and no full-word read.
- R8: If MAX_POLLS status reads have been taken without a confirmation, the result is `fail`. A confirmation that arrives on the MAX_POLLS-th read still proceeds normally.
- R9: `done` and `fail` are never high together. Either one holds, with `busy` low, until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling; pulse after the command's final write strobe |
| pollMode | input | 1 | 0: data-complement on bit 7, 1: toggle on bit 6; sampled at `start` |
| isErase | input | 1 | 1 when the operation is an erase; sampled at `start` |
| expData | input | DATA_W | Word being programmed; sampled at `start` |
| rdReq | output | 1 | Read request to the flash read port |
| rdAck | input | 1 | Read completes; `rdData` valid this cycle |
| rdData | input | DATA_W | Word returned by the flash |
| busy | output | 1 | Polling, settling or checking |
| done | output | 1 | Operation completed and verified |
| fail | output | 1 | Status-read budget exhausted or final word wrong |

## Verification
The flash model answers each read according to a programmable busy length. It can also inject a single stray finished-looking read, which tells a poller that confirms completion apart from one that trusts the first good read.

- Data-complement runs cover program words with flag bit 0 and flag bit 1, and an erase. Together they separate the two target polarities.
- During the settle interval, the model's data bus stays corrupted for most of that interval. A poller that skips or shortens the wait reads a bad word.
- A run with a wrong final word must end in `fail`.
- Toggle runs include a zero-length busy phase, which shows that the first read is not compared against anything.
- Runs whose busy length lands exactly at, and one past, the read budget pin down where the timeout falls.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL,
    ST_SETTLE,
    ST_CHECK,
    ST_DONE,
    ST_FAIL
  } pollState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic takeStatus;
    logic runSettle;
  } pollCtl_t;

  // decisions from datapath to control
  typedef struct packed {
    logic confirmed;
    logic lastPoll;
    logic settleEnd;
    logic wordOk;
    logic toggleMode;
  } pollFlags_t;

endpackage

// File: rtl/flash_poll_datapath.sv
module flash_poll_datapath
  import flash_poll_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FLAG_BIT   = 7,
  parameter int TOGGLE_BIT = 6,
  parameter int MAX_POLLS  = 1000,
  parameter int SETTLE_CYC = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  pollCtl_t          ctl,
  input  logic              pollMode,
  input  logic              isErase,
  input  logic [DATA_W-1:0] expData,
  input  logic [DATA_W-1:0] rdData,
  output pollFlags_t        flags
);

  localparam int CNT_W = $clog2(MAX_POLLS + 1);
  localparam int SET_W = $clog2(SETTLE_CYC + 1);

  logic              modeReg;
  logic              eraseReg;
  logic [DATA_W-1:0] expReg;
  logic              prevBit;
  logic              prevValid;
  logic [1:0]        confCnt;
  logic [CNT_W-1:0]  pollCnt;
  logic [SET_W-1:0]  settleCnt;

  logic              flagTarget;
  logic [DATA_W-1:0] wordTarget;
  logic              statusOk;

  always_comb begin
    flagTarget = eraseReg ? 1'b1 : expReg[FLAG_BIT];
    wordTarget = eraseReg ? {DATA_W{1'b1}} : expReg;
    if (modeReg) statusOk = prevValid && (rdData[TOGGLE_BIT] == prevBit);
    else         statusOk = (rdData[FLAG_BIT] == flagTarget);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg   <= 1'b0;
      eraseReg  <= 1'b0;
      expReg    <= '0;
      prevBit   <= 1'b0;
      prevValid <= 1'b0;
      confCnt   <= '0;
      pollCnt   <= '0;
      settleCnt <= '0;
    end else if (ctl.loadCfg) begin
      modeReg   <= pollMode;
      eraseReg  <= isErase;
      expReg    <= expData;
      prevValid <= 1'b0;
      confCnt   <= '0;
      pollCnt   <= '0;
      settleCnt <= '0;
    end else begin
      if (ctl.takeStatus) begin
        prevBit   <= rdData[TOGGLE_BIT];
        prevValid <= 1'b1;
        pollCnt   <= pollCnt + 1'b1;
        if (!statusOk)             confCnt <= '0;
        else if (confCnt != 2'd2)  confCnt <= confCnt + 1'b1;
      end
      if (ctl.runSettle) settleCnt <= settleCnt + 1'b1;
    end
  end

  always_comb begin
    flags.confirmed  = statusOk && (confCnt == 2'd2);
    flags.lastPoll   = (pollCnt == CNT_W'(MAX_POLLS - 1));
    flags.settleEnd  = (settleCnt == SET_W'(SETTLE_CYC - 1));
    flags.wordOk     = (rdData == wordTarget);
    flags.toggleMode = modeReg;
  end

endmodule

// File: rtl/flash_poll_control.sv
module flash_poll_control
  import flash_poll_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       rdAck,
  input  pollFlags_t flags,
  output pollCtl_t   ctl,
  output logic       rdReq,
  output logic       busy,
  output logic       done,
  output logic       fail
);

  pollState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    case (state)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start) begin
          ctl.loadCfg = 1'b1;
          nextState   = ST_POLL;
        end
      end
      ST_POLL: begin
        if (rdAck) begin
          ctl.takeStatus = 1'b1;
          if (flags.confirmed)     nextState = flags.toggleMode ? ST_DONE : ST_SETTLE;
          else if (flags.lastPoll) nextState = ST_FAIL;
        end
      end
      ST_SETTLE: begin
        ctl.runSettle = 1'b1;
        if (flags.settleEnd) nextState = ST_CHECK;
      end
      ST_CHECK: begin
        if (rdAck) nextState = flags.wordOk ? ST_DONE : ST_FAIL;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    rdReq = (state == ST_POLL) || (state == ST_CHECK);
    busy  = rdReq || (state == ST_SETTLE);
    done  = (state == ST_DONE);
    fail  = (state == ST_FAIL);
  end

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import flash_poll_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int FLAG_BIT      = 7,
  parameter int TOGGLE_BIT    = 6,
  parameter int MAX_POLLS     = 1000,
  parameter int CLK_PERIOD_PS = 5000,
  parameter int SETTLE_NS     = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              pollMode,
  input  logic              isErase,
  input  logic [DATA_W-1:0] expData,
  output logic              rdReq,
  input  logic              rdAck,
  input  logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              done,
  output logic              fail
);

  localparam int SETTLE_RAW = (SETTLE_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;

  pollCtl_t   ctl;
  pollFlags_t flags;

  flash_poll_datapath #(
    .DATA_W    (DATA_W),
    .FLAG_BIT  (FLAG_BIT),
    .TOGGLE_BIT(TOGGLE_BIT),
    .MAX_POLLS (MAX_POLLS),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .pollMode(pollMode),
    .isErase (isErase),
    .expData (expData),
    .rdData  (rdData),
    .flags   (flags)
  );

  flash_poll_control u_control (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .rdAck(rdAck),
    .flags(flags),
    .ctl  (ctl),
    .rdReq(rdReq),
    .busy (busy),
    .done (done),
    .fail (fail)
  );

endmodule

// File: rtl/flash_poll_checker.sv
module flash_poll_checker (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic rdReq,
  input logic rdAck,
  input logic busy,
  input logic done,
  input logic fail
);

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN) !busy |-> !rdReq); // R2
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN) (rdReq && !rdAck) |=> rdReq); // R2
  AST_START_POLLS: assert property (@(posedge clk) disable iff (!rstN) (start && !busy) |=> (busy && rdReq)); // R2
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rstN) !(done && fail)); // R9
  AST_RESULT_IDLE: assert property (@(posedge clk) disable iff (!rstN) (done || fail) |-> !busy); // R9
  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rstN) (done && !start) |=> done); // R9
  AST_FAIL_HELD: assert property (@(posedge clk) disable iff (!rstN) (fail && !start) |=> fail); // R9

endmodule

bind flash_done_poller flash_poll_checker u_pollChk (
  .clk  (clk),
  .rstN (rstN),
  .start(start),
  .rdReq(rdReq),
  .rdAck(rdAck),
  .busy (busy),
  .done (done),
  .fail (fail)
);

// File: tb/test_flash_done_poller.sv
module test_flash_done_poller;

  localparam int POLLS  = 32;
  localparam int SETTLE = 200; // 1000 ns at 5000 ps per cycle

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        pollMode = 1'b0;
  logic        isErase = 1'b0;
  logic [15:0] expData = '0;
  logic        rdReq;
  logic        rdAck = 1'b0;
  logic [15:0] rdData = '0;
  logic        busy, done, fail;

  int testsRun = 0;
  int testsFailed = 0;

  // flash model state
  int          cyc = 0;
  int          readIdx = 0;
  int          mBusy = 0;
  int          mGlitch = -1;
  int          mInvalid = 0;
  int          tComp = -1;
  bit          mErase = 1'b0;
  bit          mTog = 1'b0;
  logic [15:0] mTrue = '0;

  always #2.5 clk = ~clk;

  flash_done_poller #(.MAX_POLLS(POLLS)) i_flash_done_poller (
    .clk(clk), .rstN(rstN), .start(start), .pollMode(pollMode),
    .isErase(isErase), .expData(expData), .rdReq(rdReq), .rdAck(rdAck),
    .rdData(rdData), .busy(busy), .done(done), .fail(fail)
  );

  always @(posedge clk) begin : flashModel
    logic [15:0] w;
    bit          bz;
    cyc = cyc + 1;
    if (rdReq && !rdAck) begin
      bz = (readIdx < mBusy) && (readIdx != mGlitch);
      if (bz) begin
        mTog  = ~mTog;
        w     = mTrue ^ 16'h5500;
        w[7]  = mErase ? 1'b0 : ~mTrue[7];
        w[6]  = mTog;
      end else begin
        if (readIdx >= mBusy && tComp < 0) tComp = cyc;
        if (tComp < 0 || (cyc - tComp) < mInvalid) begin
          w    = mTrue ^ 16'h0A00;
          w[7] = mErase ? 1'b1 : mTrue[7];
          w[6] = mTog;
        end else begin
          w = mTrue;
        end
      end
      readIdx = readIdx + 1;
      rdData <= w;
      rdAck  <= 1'b1;
    end else begin
      rdAck <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic runOp(input bit md, input bit er, input logic [15:0] ex,
                       input logic [15:0] tw, input int b, input int g, input int inv,
                       output int reads, output int quiet, output bit gotDone);
    @(negedge clk);
    mBusy = b; mGlitch = g; mInvalid = inv; mErase = er; mTrue = tw;
    mTog = 1'b0; tComp = -1; readIdx = 0;
    pollMode = md; isErase = er; expData = ex; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && rdReq && !done && !fail, "R2 start opens polling", int'(rdReq), 1);
    quiet = 0;
    while (!(done || fail)) begin
      if (busy && !rdReq) quiet++;
      @(negedge clk);
    end
    reads = readIdx;
    gotDone = done;
  endtask

  task automatic tcReset();
    chk(!busy && !done && !fail && !rdReq, "R1 idle after reset", int'({busy, done, fail, rdReq}), 0);
  endtask

  task automatic tcProgLow();
    int r, q; bit d;
    runOp(1'b0, 1'b0, 16'h1234, 16'h1234, 5, -1, 190, r, q, d);
    chk(d, "R3 program flag 0 completes", int'(d), 1);
    chk(r == 9, "R5 three good status reads then word read", r, 9);
    chk(q == SETTLE, "R6 settle interval length", q, SETTLE);
    repeat (5) @(negedge clk);
    chk(done && !fail && !busy && !rdReq, "R9 done held", int'({done, fail, busy, rdReq}), 8);
  endtask

  task automatic tcProgHigh();
    int r, q; bit d;
    runOp(1'b0, 1'b0, 16'h00A5, 16'h00A5, 3, -1, 0, r, q, d);
    chk(d && r == 7, "R3 program flag 1 completes", r, 7);
  endtask

  task automatic tcEraseGlitch();
    int r, q; bit d;
    runOp(1'b0, 1'b1, 16'h0000, 16'hFFFF, 6, 2, 0, r, q, d);
    chk(d, "R3 erase completes on flag 1", int'(d), 1);
    chk(r == 10, "R5 stray good read not trusted (erase)", r, 10);
  endtask

  task automatic tcToggle();
    int r, q; bit d;
    runOp(1'b1, 1'b0, 16'h0000, 16'h0000, 7, -1, 100000, r, q, d);
    chk(d && r == 10, "R4 toggle stops detected", r, 10);
    chk(q == 0, "R7 no settle in toggle mode", q, 0);
  endtask

  task automatic tcToggleFirst();
    int r, q; bit d;
    runOp(1'b1, 1'b0, 16'h0000, 16'h0000, 0, -1, 100000, r, q, d);
    chk(d && r == 4, "R4 first read never counts", r, 4);
  endtask

  task automatic tcToggleGlitch();
    int r, q; bit d;
    runOp(1'b1, 1'b0, 16'h0000, 16'h0000, 8, 4, 100000, r, q, d);
    chk(d && r == 11, "R5 stray good read not trusted (toggle)", r, 11);
  endtask

  task automatic tcMismatch();
    int r, q; bit d;
    runOp(1'b0, 1'b0, 16'h1234, 16'h1235, 4, -1, 0, r, q, d);
    chk(!d && fail, "R6 wrong final word gives fail", int'(fail), 1);
    chk(r == 8, "R6 one word read after settle", r, 8);
  endtask

  task automatic tcTimeout();
    int r, q; bit d;
    runOp(1'b1, 1'b0, 16'h0000, 16'h0000, 1000, -1, 100000, r, q, d);
    chk(!d && fail, "R8 stuck operation fails", int'(fail), 1);
    chk(r == POLLS, "R8 budget of status reads", r, POLLS);
    repeat (4) @(negedge clk);
    chk(fail && !done && !busy, "R9 fail held", int'({fail, done, busy}), 4);
  endtask

  task automatic tcBudgetEdge();
    int r, q; bit d;
    runOp(1'b0, 1'b0, 16'h0042, 16'h0042, POLLS - 3, -1, 0, r, q, d);
    chk(d && r == POLLS + 1, "R8 confirm on last allowed read", r, POLLS + 1);
    runOp(1'b0, 1'b0, 16'h0042, 16'h0042, POLLS - 2, -1, 0, r, q, d);
    chk(!d && fail && r == POLLS, "R8 confirm one read late", r, POLLS);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    tcReset();
    rstN = 1'b1;
    @(negedge clk);
    tcReset();
    tcProgLow();
    tcProgHigh();
    tcEraseGlitch();
    tcToggle();
    tcToggleFirst();
    tcToggleGlitch();
    tcMismatch();
    tcTimeout();
    tcBudgetEdge();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule